// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block is a four-wire serial slave that lets a host controller read and write an on-chip register file. The host pulls the select line low, then clocks in an address byte made of a fixed seven-bit device identifier and a direction bit. On a write, the next byte loads an internal register pointer. Any later bytes are written to the register the pointer selects, and the pointer advances after each one. On a read, no pointer byte follows. The port returns register contents starting at the pointer left by earlier transactions, again advancing after each byte.

All serial inputs pass through synchronisers into the block's own clock domain, and the serial clock's edges are found in that domain. Input data is captured on the rising serial-clock edge. Returned data changes after the falling edge. The data output is modelled as a value plus an output enable, and the enable is asserted only while read data is being returned.

The controller moves through these states: `ST_IDLE` (deselected), `ST_CHIP` (taking the address byte), `ST_PTR` (taking the pointer byte), `ST_WDATA` (write data bytes), `ST_RDATA` (read data bytes) and `ST_SKIP` (identifier mismatch). Its transitions are:
- Any state goes to IDLE whenever select is high.
- IDLE goes to CHIP while select is low.
- At the end of the address byte, CHIP goes to PTR on a matching write, to RDATA on a matching read, and to SKIP on a mismatch.
- PTR goes to WDATA at the end of the pointer byte.
- WDATA, RDATA and SKIP stay where they are until deselect.

Top module: `spi_reg_port`

## Requirements
- R1: The first byte after select falls is taken MSB first. Its upper seven bits must equal the identifier 0010000, and its bit 0 gives the direction: 0 for write, 1 for read.
- R2: In a write transaction, the second byte is loaded MSB first into the register pointer. A transaction may end right after it, and then it only sets the pointer.
- R3: Each later write byte gives a `reg_wr_en` pulse one clock long, with `reg_wr_addr` equal to the pointer and `reg_wr_data` equal to the byte. The pointer then increments, wrapping from 255 to 0.
- R4: In a read transaction, bytes are returned MSB first. The first byte comes from the pointer held since earlier transactions. The pointer increments after each byte and wraps from 255 to 0.
- R5: `cdout_oe` is low at all times other than the data phase of a read with a matching identifier. This covers deselect, the address byte and writes.
- R6: When the identifier does not match, the rest of the transaction causes no register write, no pointer change and no output drive.
- R7: Raising select abandons the transfer at once. A partly received byte is dropped, and the next transaction starts counting bits from zero.
- R8: `cdin` is sampled at the rising edge of `cclk`, and each returned bit appears on `cdout` after the preceding falling edge of `cclk`.
- R9: After reset, the pointer is 0, and `cdout_oe` and `reg_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| cclk | input | 1 | Serial clock from the host, idles low |
| cdin | input | 1 | Serial data from the host |
| cdout | output | 1 | Serial read data value |
| cdout_oe | output | 1 | High when `cdout` should be driven; otherwise the pin floats |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | W | Register write address |
| reg_wr_data | output | W | Register write data |
| reg_rd_addr | output | W | Register read address |
| reg_rd_data | input | W | Register read data, valid in the same cycle as `reg_rd_addr` |

## Verification
The assertions assume that `cclk` half-periods last several block clocks. Under that assumption, byte ends are at least eight serial edges apart, and a write strobe can never be followed by another in the next cycle. They also assume `cs_n` stays high for several block clocks when the host deselects, so the output enable has time to fall after the synchroniser delay. The bench holds each serial-clock phase for five block clocks and holds select high for at least six clocks between transactions. It changes `cdin` only together with the falling serial-clock edge, which keeps data stable around every rising edge.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHIP,
        ST_PTR,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } port_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic cclk,
    input  logic cdin,
    output logic cs_n_s,
    output logic cdin_s,
    output logic cclk_rise,
    output logic cclk_fall
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] cs_sh;
    logic [STAGES-1:0] ck_sh;
    logic [STAGES-1:0] di_sh;
    logic              ck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_sh   <= '1;
            ck_sh   <= '0;
            di_sh   <= '0;
            ck_prev <= 1'b0;
        end else begin
            cs_sh   <= {cs_sh[STAGES-2:0], cs_n};
            ck_sh   <= {ck_sh[STAGES-2:0], cclk};
            di_sh   <= {di_sh[STAGES-2:0], cdin};
            ck_prev <= ck_sh[TOP];
        end
    end

    assign cs_n_s    = cs_sh[TOP];
    assign cdin_s    = di_sh[TOP];
    assign cclk_rise = ck_sh[TOP] & ~ck_prev;
    assign cclk_fall = ~ck_sh[TOP] & ck_prev;

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         rise,
    input  logic         fall,
    input  logic         bit_in,
    input  logic         tx_load,
    input  logic         tx_shift_en,
    input  logic [W-1:0] tx_data,
    output logic [W-1:0] rx_full,
    output logic         byte_done,
    output logic         bit_out
);
    localparam int          CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0]     rx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     tx_q;
    logic             out_q;

    assign rx_full   = {rx_q[W-2:0], bit_in};
    assign byte_done = rise && !clear && (cnt_q == LAST);
    assign bit_out   = out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (rise) begin
            rx_q  <= rx_full;
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            out_q <= 1'b0;
        end else if (tx_load) begin
            tx_q <= tx_data;
        end else if (fall && tx_shift_en) begin
            out_q <= tx_q[W-1];
            tx_q  <= {tx_q[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/spi_port_fsm.sv
module spi_port_fsm
    import spi_reg_pkg::*;
#(
    parameter int             W       = 8,
    parameter logic [W-2:0]   CHIP_ID = 7'b0010000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          byte_done,
    input  logic [W-1:0]  rx_full,
    output port_state_t   state,
    output logic [W-1:0]  ptr,
    output logic          wr_en,
    output logic [W-1:0]  rd_addr,
    output logic          tx_load,
    output logic          tx_shift_en,
    output logic          oe
);
    port_state_t  state_q;
    port_state_t  state_d;
    logic [W-1:0] ptr_q;
    logic         id_match;
    logic         is_read;

    assign id_match = (rx_full[W-1:1] == CHIP_ID);
    assign is_read  = rx_full[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cs_n_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_CHIP;
                ST_CHIP:  if (byte_done)
                              state_d = !id_match ? ST_SKIP :
                                        (is_read ? ST_RDATA : ST_PTR);
                ST_PTR:   if (byte_done) state_d = ST_WDATA;
                ST_WDATA: state_d = ST_WDATA;
                ST_RDATA: state_d = ST_RDATA;
                ST_SKIP:  state_d = ST_SKIP;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (byte_done && !cs_n_s) begin
            if (state_q == ST_PTR)
                ptr_q <= rx_full;
            else if (state_q == ST_WDATA || state_q == ST_RDATA)
                ptr_q <= ptr_q + 1'b1;
        end
    end

    always_comb begin
        wr_en       = 1'b0;
        tx_load     = 1'b0;
        tx_shift_en = 1'b0;
        oe          = 1'b0;
        rd_addr     = ptr_q;
        unique case (state_q)
            ST_CHIP:  tx_load = byte_done && id_match && is_read;
            ST_WDATA: wr_en   = byte_done;
            ST_RDATA: begin
                oe          = 1'b1;
                tx_shift_en = 1'b1;
                tx_load     = byte_done;
                rd_addr     = ptr_q + 1'b1;
            end
            default: ;
        endcase
        if (cs_n_s) begin
            wr_en   = 1'b0;
            tx_load = 1'b0;
        end
    end

    assign state = state_q;
    assign ptr   = ptr_q;

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
    import spi_reg_pkg::*;
#(
    parameter int           W           = 8,
    parameter logic [W-2:0] CHIP_ID     = 7'b0010000,
    parameter int           SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         cclk,
    input  logic         cdin,
    output logic         cdout,
    output logic         cdout_oe,
    output logic         reg_wr_en,
    output logic [W-1:0] reg_wr_addr,
    output logic [W-1:0] reg_wr_data,
    output logic [W-1:0] reg_rd_addr,
    input  logic [W-1:0] reg_rd_data
);
    logic         cs_n_s;
    logic         cdin_s;
    logic         cclk_rise;
    logic         cclk_fall;
    logic [W-1:0] rx_full;
    logic         byte_done;
    logic         tx_load;
    logic         tx_shift_en;
    logic [W-1:0] map_ptr;
    port_state_t  port_state;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cclk      (cclk),
        .cdin      (cdin),
        .cs_n_s    (cs_n_s),
        .cdin_s    (cdin_s),
        .cclk_rise (cclk_rise),
        .cclk_fall (cclk_fall)
    );

    spi_byte_shifter #(.W(W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (cs_n_s),
        .rise        (cclk_rise),
        .fall        (cclk_fall),
        .bit_in      (cdin_s),
        .tx_load     (tx_load),
        .tx_shift_en (tx_shift_en),
        .tx_data     (reg_rd_data),
        .rx_full     (rx_full),
        .byte_done   (byte_done),
        .bit_out     (cdout)
    );

    spi_port_fsm #(.W(W), .CHIP_ID(CHIP_ID)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_s      (cs_n_s),
        .byte_done   (byte_done),
        .rx_full     (rx_full),
        .state       (port_state),
        .ptr         (map_ptr),
        .wr_en       (reg_wr_en),
        .rd_addr     (reg_rd_addr),
        .tx_load     (tx_load),
        .tx_shift_en (tx_shift_en),
        .oe          (cdout_oe)
    );

    assign reg_wr_addr = map_ptr;
    assign reg_wr_data = rx_full;

endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         cdout_oe,
    input logic         reg_wr_en,
    input logic [W-1:0] reg_wr_addr,
    input logic [W-1:0] ptr
);
    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en); // R3

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (ptr == $past(reg_wr_addr) + 1'b1)); // R3

    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !cdout_oe); // R5

    AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
        |-> !cdout_oe); // R7

endmodule

bind spi_reg_port spi_reg_port_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .cdout_oe    (cdout_oe),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .ptr         (map_ptr)
);

// File: tb/tb_spi_reg_port.sv
module tb_spi_reg_port;
    localparam int W    = 8;
    localparam int HALF = 5;
    localparam logic [6:0] ID = 7'b0010000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         cclk = 1'b0;
    logic         cdin = 1'b0;
    logic         cdout;
    logic         cdout_oe;
    logic         reg_wr_en;
    logic [W-1:0] reg_wr_addr;
    logic [W-1:0] reg_wr_data;
    logic [W-1:0] reg_rd_addr;
    logic [W-1:0] reg_rd_data;

    logic [7:0] model [256];
    int checks = 0;
    int fails = 0;
    int wr_count = 0;
    int oe_viol = 0;
    bit oe_allowed = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_reg_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cclk(cclk), .cdin(cdin),
        .cdout(cdout), .cdout_oe(cdout_oe), .reg_wr_en(reg_wr_en),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
    );

    assign reg_rd_data = model[reg_rd_addr];

    function automatic logic [7:0] fpat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 256; a++) model[a] <= 8'(a) ^ 8'h5A;
        end else if (reg_wr_en) begin
            model[reg_wr_addr] <= reg_wr_data;
            wr_count <= wr_count + 1;
        end
    end

    always @(negedge clk) if (rst_n && cdout_oe && !oe_allowed) oe_viol++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic q, output logic oe);
        cdin = b;
        repeat (HALF) @(negedge clk);
        q  = cdout;
        oe = cdout_oe;
        cclk = 1'b1;
        repeat (HALF) @(negedge clk);
        cclk = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
        logic q, oe;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sbit(tx[i], q, oe);
            rx[i] = q;
            oe_all = oe_all & oe;
        end
    endtask

    task automatic begin_txn();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic end_txn();
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        oe_allowed = 1'b0;
    endtask

    task automatic read_run(input int start, input int n, input bit init_pat, input string req);
        logic [7:0] rx, expv;
        logic oe_all;
        oe_allowed = 1'b1;
        begin_txn();
        sbyte({ID, 1'b1}, rx, oe_all);
        for (int i = 0; i < n; i++) begin
            sbyte(8'h00, rx, oe_all);
            expv = init_pat ? (8'((start + i) & 255) ^ 8'h5A) : fpat((start + i) & 255);
            chk(rx == expv, req, rx, expv);
            chk(oe_all == 1'b1, "R4 oe during read data", oe_all, 1);
        end
        end_txn();
    endtask

    initial begin
        logic [7:0] rx;
        logic oe_all, q, oe;
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(cdout_oe == 1'b0, "R9 oe after reset", cdout_oe, 0);
        chk(reg_wr_en == 1'b0, "R9 wr_en after reset", reg_wr_en, 0);
        // R9 pointer starts at 0; R4 R8 read MSB first
        read_run(0, 2, 1'b1, "R9 R4 R8 read after reset");

        // R1 R2 R3: burst write of 256 bytes from 0x10, wrapping
        base = wr_count;
        begin_txn();
        sbyte({ID, 1'b0}, rx, oe_all);
        sbyte(8'h10, rx, oe_all);
        for (int i = 0; i < 256; i++) sbyte(fpat((16 + i) & 255), rx, oe_all);
        end_txn();
        chk(wr_count - base == 256, "R3 write strobe count", wr_count - base, 256);
        for (int a = 0; a < 256; a++) chk(model[a] == fpat(a), "R3 R1 written value", model[a], fpat(a));
        chk(oe_viol == 0, "R5 no drive during write", oe_viol, 0);

        // R4 read burst wrapping past 255
        read_run(16, 257, 1'b0, "R4 R8 read burst");

        // R2 pointer-only write then read
        begin_txn();
        sbyte({ID, 1'b0}, rx, oe_all);
        sbyte(8'hF0, rx, oe_all);
        end_txn();
        read_run(240, 20, 1'b0, "R2 R4 read from written pointer");

        // R6 sweep of all non-matching identifiers
        base = wr_count;
        for (int id = 0; id < 128; id++) begin
            if (id == 16) continue;
            begin_txn();
            sbyte({7'(id), 1'(id & 1)}, rx, oe_all);
            sbyte(8'h33, rx, oe_all);
            sbyte(8'hC3, rx, oe_all);
            end_txn();
        end
        chk(wr_count == base, "R6 no write on mismatch", wr_count - base, 0);
        chk(oe_viol == 0, "R6 R5 no drive on mismatch", oe_viol, 0);
        read_run(4, 1, 1'b0, "R6 pointer unchanged by mismatch");

        // R7 abort during a data byte
        base = wr_count;
        begin_txn();
        sbyte({ID, 1'b0}, rx, oe_all);
        sbyte(8'h40, rx, oe_all);
        for (int i = 0; i < 4; i++) sbit(1'b1, q, oe);
        end_txn();
        chk(wr_count == base, "R7 partial byte dropped", wr_count - base, 0);
        chk(model[8'h40] == fpat(64), "R7 target untouched", model[8'h40], fpat(64));
        begin_txn();
        sbyte({ID, 1'b0}, rx, oe_all);
        sbyte(8'h41, rx, oe_all);
        sbyte(8'h9C, rx, oe_all);
        end_txn();
        chk(wr_count - base == 1, "R7 next write counted", wr_count - base, 1);
        chk(model[8'h41] == 8'h9C, "R7 fresh transaction write", model[8'h41], 8'h9C);

        // R7 abort inside the address byte, then a clean read
        begin_txn();
        sbit(1'b1, q, oe);
        sbit(1'b0, q, oe);
        sbit(1'b1, q, oe);
        end_txn();
        read_run(66, 1, 1'b0, "R7 read after aborted address");
        chk(oe_viol == 0, "R5 final drive check", oe_viol, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule